// File: doc/BRIEF.md
# Packet Memory Pointer Window

This block lets a host reach packet buffer memory one byte at a time through a small register window. The host loads a 16-bit pointer as two bytes. It then reads or writes through a four-byte data window. Each data access is turned into one access on an external synchronous page RAM. That RAM holds several pages of 2048 bytes each.

Two control bits in the pointer set how the access is steered. Bit 15 chooses the page:
- When bit 15 is set, the page is the one at the head of the receive queue.
- When bit 15 is clear, the page is the one held in the packet-number register.

Bit 14 chooses how the byte address is formed:
- When bit 14 is set, the 11-bit page offset steps forward after every data access.
- When bit 14 is clear, the data-window lane is added to the offset, and the pointer does not move.

Read data comes back one cycle after the request, marked by a valid strobe.

Top module: `pkt_window_top`

## Requirements
- R1: After reset the pointer is zero and `reg_rvalid` is low, so reading window offsets 6 and 7 returns 0x00.
- R2: A write at window offset 6 loads pointer bits 7:0, and a write at offset 7 loads pointer bits 15:8. A read at offset 6 returns bits 7:0. A read at offset 7 returns bits 15:8 ANDed with 0xF7, so bit 11 always reads as zero.
- R3: The RAM address is {page, offset}, with the page in the upper bits. The page is `rxq_head` when pointer bit 15 is 1 and `pkt_num` when it is 0. The offset is pointer bits 10:0.
- R4: With pointer bit 14 set, each data read or write uses the current offset. Afterwards, bits 10:0 increment and wrap within 11 bits, and bits 15:11 stay the same. The window lane is ignored in this mode.
- R5: With pointer bit 14 clear, the byte offset is (pointer bits 10:0 + lane) modulo 2048. The lane is window offset bits 1:0, for offsets 8 to 11. The pointer is unchanged by the access.
- R6: Every `reg_rd` pulse is answered by exactly one `reg_rvalid` pulse in the next cycle, with `reg_rdata` valid in that cycle. For a data read, the byte is the RAM output for the address presented with the request.
- R7: A data-window write drives `ram_en` and `ram_we` in the same cycle, with `ram_wdata` equal to `reg_wdata`.
- R8: Writes to window offsets other than 6 to 11 change nothing, and reads from them return 0x00.
- R9: `ram_en` is high only during a data-window access at offsets 8 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 4 | Window byte offset |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read return strobe |
| rxq_head | input | PG_W | Page number at the head of the receive queue |
| pkt_num | input | PG_W | Page number from the packet-number register |
| ram_en | output | 1 | Page RAM access enable |
| ram_we | output | 1 | Page RAM write enable |
| ram_addr | output | PG_W+OFF_W | Page RAM byte address |
| ram_wdata | output | 8 | Page RAM write byte |
| ram_rdata | input | 8 | Page RAM read byte, one cycle after ram_en |

## Verification
The bench builds the block with its defaults: four pages of 2048 bytes, so the page field is 2 bits wide and the offset field is 11 bits wide. With these sizes the bench can place the pointer at offset 0x7FF, which reaches both wrap cases: the auto-increment wrap back to offset zero, and the lane-add wrap in indexed mode. With distinct values on `rxq_head` and `pkt_num`, the bench can tell the two page sources apart by the bytes it reads back from its RAM model.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam logic [3:0] WIN_PTR_LO = 4'd6;
  localparam logic [3:0] WIN_PTR_HI = 4'd7;
  localparam logic [1:0] WIN_DATA_HI = 2'b10;
  localparam int PTR_SRC_BIT = 15;
  localparam int PTR_INC_BIT = 14;
  localparam logic [7:0] HI_READ_MASK = 8'hF7;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_PTR_LO = 2'd1,
    ACC_PTR_HI = 2'd2,
    ACC_DATA   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/pdw_decode.sv
module pdw_decode
  import pdw_pkg::*;
(
  input  logic [3:0] off,
  output acc_kind_e  kind,
  output logic [1:0] lane
);
  always_comb begin
    kind = ACC_NONE;
    if (off[3:2] == WIN_DATA_HI) kind = ACC_DATA;
    else if (off == WIN_PTR_LO)  kind = ACC_PTR_LO;
    else if (off == WIN_PTR_HI)  kind = ACC_PTR_HI;
    lane = off[1:0];
  end
endmodule

// File: rtl/pdw_pointer.sv
module pdw_pointer
  import pdw_pkg::*;
#(
  parameter int OFF_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  wdata,
  input  logic        data_acc,
  output logic [15:0] ptr
);
  logic [15:0] ptr_q, ptr_d;
  logic        ptr_en;
  logic        step;

  always_comb begin
    step   = data_acc && ptr_q[PTR_INC_BIT];
    ptr_d  = ptr_q;
    if (wr_lo) ptr_d[7:0]  = wdata;
    if (wr_hi) ptr_d[15:8] = wdata;
    if (step)  ptr_d[OFF_W-1:0] = ptr_q[OFF_W-1:0] + OFF_W'(1);
    ptr_en = wr_lo || wr_hi || step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  assert_autoinc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && ptr_q[PTR_INC_BIT]) |=>
      (ptr_q[OFF_W-1:0] == OFF_W'($past(ptr_q[OFF_W-1:0]) + OFF_W'(1))) &&
      (ptr_q[15:OFF_W] == $past(ptr_q[15:OFF_W])));

  assert_indexed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ptr_q[PTR_INC_BIT]) |=> $stable(ptr_q));
endmodule

// File: rtl/pdw_addr.sv
module pdw_addr
  import pdw_pkg::*;
#(
  parameter int OFF_W = 11,
  parameter int PG_W  = 2
) (
  input  logic [15:0]          ptr,
  input  logic [PG_W-1:0]      rxq_head,
  input  logic [PG_W-1:0]      pkt_num,
  input  logic [1:0]           lane,
  output logic [PG_W+OFF_W-1:0] addr
);
  logic [PG_W-1:0]  page;
  logic [OFF_W-1:0] off;

  always_comb begin
    page = ptr[PTR_SRC_BIT] ? rxq_head : pkt_num;
    if (ptr[PTR_INC_BIT]) off = ptr[OFF_W-1:0];
    else                  off = ptr[OFF_W-1:0] + OFF_W'(lane);
    addr = {page, off};
  end
endmodule

// File: rtl/pdw_rdret.sv
module pdw_rdret (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd,
  input  logic       from_ram,
  input  logic [7:0] reg_byte,
  input  logic [7:0] ram_rdata,
  output logic [7:0] rdata,
  output logic       rvalid
);
  logic       vld_q;
  logic       src_q;
  logic [7:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      src_q <= 1'b0;
    end else begin
      vld_q <= rd;
      if (rd) src_q <= from_ram;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_q <= '0;
    else if (rd && !from_ram)  hold_q <= reg_byte;
  end

  assign rvalid = vld_q;
  assign rdata  = src_q ? ram_rdata : hold_q;

  assert_rvalid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  assert_no_spurious_rvalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
endmodule

// File: rtl/pkt_window_top.sv
module pkt_window_top
  import pdw_pkg::*;
#(
  parameter int PAGE_CNT   = 4,
  parameter int PAGE_BYTES = 2048,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = $clog2(PAGE_CNT),
  localparam int ADDR_W = PG_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_off,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              reg_rvalid,
  input  logic [PG_W-1:0]   rxq_head,
  input  logic [PG_W-1:0]   pkt_num,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);
  acc_kind_e   kind;
  logic [1:0]  lane;
  logic [15:0] ptr;
  logic        data_acc;
  logic [7:0]  reg_byte;

  pdw_decode u_dec (.off(reg_off), .kind(kind), .lane(lane));

  assign data_acc = (reg_wr || reg_rd) && (kind == ACC_DATA);

  pdw_pointer #(.OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(reg_wr && kind == ACC_PTR_LO),
    .wr_hi(reg_wr && kind == ACC_PTR_HI),
    .wdata(reg_wdata), .data_acc(data_acc), .ptr(ptr)
  );

  pdw_addr #(.OFF_W(OFF_W), .PG_W(PG_W)) u_addr (
    .ptr(ptr), .rxq_head(rxq_head), .pkt_num(pkt_num),
    .lane(lane), .addr(ram_addr)
  );

  always_comb begin
    case (kind)
      ACC_PTR_LO: reg_byte = ptr[7:0];
      ACC_PTR_HI: reg_byte = ptr[15:8] & HI_READ_MASK;
      default:    reg_byte = 8'h00;
    endcase
  end

  assign ram_en    = data_acc;
  assign ram_we    = data_acc && reg_wr;
  assign ram_wdata = reg_wdata;

  pdw_rdret u_ret (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd),
    .from_ram(kind == ACC_DATA), .reg_byte(reg_byte),
    .ram_rdata(ram_rdata), .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  assert_single_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  assert_ram_only_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (reg_off >= 4'd8 && reg_off <= 4'd11));
  assert_write_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_en && reg_wr && ram_wdata == reg_wdata));
  assert_hi_bit11_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_off == WIN_PTR_HI) |=> !reg_rdata[3]);
endmodule

// File: tb/tb_pkt_window_top.sv
`timescale 1ns/1ps
module tb_pkt_window_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [3:0]  reg_off;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        reg_rvalid;
  logic [1:0]  rxq_head, pkt_num;
  logic        ram_en, ram_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [7:0]  mem [8192];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkt_window_top dut (.*);

  always_ff @(posedge clk) begin
    if (ram_en && ram_we) mem[ram_addr] <= ram_wdata;
    else if (ram_en)      ram_rdata <= mem[ram_addr];
  end

  typedef struct packed {
    logic       rd;
    logic [3:0] off;
    logic [7:0] val;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd6,  8'h10, 4'd2},
    '{1'b0, 4'd7,  8'h40, 4'd2},
    '{1'b0, 4'd8,  8'hA1, 4'd7},
    '{1'b0, 4'd9,  8'hA2, 4'd4},
    '{1'b1, 4'd6,  8'h12, 4'd4},
    '{1'b0, 4'd6,  8'h10, 4'd2},
    '{1'b1, 4'd10, 8'hA1, 4'd4},
    '{1'b1, 4'd8,  8'hA2, 4'd4},
    '{1'b0, 4'd6,  8'h10, 4'd2},
    '{1'b0, 4'd7,  8'h00, 4'd2},
    '{1'b1, 4'd9,  8'hA2, 4'd5},
    '{1'b1, 4'd8,  8'hA1, 4'd5},
    '{1'b1, 4'd6,  8'h10, 4'd5},
    '{1'b0, 4'd7,  8'hCF, 4'd2},
    '{1'b1, 4'd7,  8'hC7, 4'd2},
    '{1'b1, 4'd3,  8'h00, 4'd8},
    '{1'b1, 4'd6,  8'h10, 4'd8}
  };

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1: return "R1"; 4'd2: return "R2"; 4'd3: return "R3";
      4'd4: return "R4"; 4'd5: return "R5"; 4'd6: return "R6";
      4'd7: return "R7"; 4'd8: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] off, input logic [7:0] d);
    reg_wr = 1'b1; reg_off = off; reg_wdata = d;
    #1;
    chk("R9", {15'd0, ram_en}, {15'd0, off >= 4'd8 && off <= 4'd11});
    if (off >= 4'd8 && off <= 4'd11) chk("R7", {7'd0, ram_we, ram_wdata}, {7'd0, 1'b1, d});
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] off, output logic [7:0] v);
    reg_rd = 1'b1; reg_off = off;
    #1;
    chk("R9", {15'd0, ram_en}, {15'd0, off >= 4'd8 && off <= 4'd11});
    @(posedge clk); @(negedge clk);
    chk("R6", {15'd0, reg_rvalid}, 16'd1);
    v = reg_rdata;
    reg_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    reg_wr = 0; reg_rd = 0; reg_off = 0; reg_wdata = 0;
    rxq_head = 2'd2; pkt_num = 2'd1;
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    mem[{2'd2, 11'h7FF}] = 8'h5E;
    mem[{2'd2, 11'h000}] = 8'h6F;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1", {15'd0, reg_rvalid}, 16'd0);
    do_rd(4'd6, v); chk("R1", {8'd0, v}, 16'h0000);
    do_rd(4'd7, v); chk("R1", {8'd0, v}, 16'h0000);
    @(negedge clk);
    chk("R6", {15'd0, reg_rvalid}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        do_rd(VECS[i].off, v);
        chk(rname(VECS[i].req), {8'd0, v}, {8'd0, VECS[i].val});
      end else begin
        do_wr(VECS[i].off, VECS[i].val);
      end
    end

    // R8: write to unused offset leaves pointer alone
    do_wr(4'd2, 8'h55);
    do_wr(4'd13, 8'h99);
    do_rd(4'd6, v); chk("R8", {8'd0, v}, 16'h0010);
    do_rd(4'd7, v); chk("R8", {8'd0, v}, 16'h00C7);

    // R3/R7: bytes landed in the packet-number page
    chk("R3", {8'd0, mem[{2'd1, 11'h010}]}, 16'h00A1);
    chk("R3", {8'd0, mem[{2'd1, 11'h011}]}, 16'h00A2);

    // R4/R3: receive-head page, auto-increment wrap at 0x7FF
    do_wr(4'd6, 8'hFF);
    do_wr(4'd7, 8'hC7);
    do_rd(4'd8, v);  chk("R3", {8'd0, v}, 16'h005E);
    do_rd(4'd11, v); chk("R4", {8'd0, v}, 16'h006F);
    do_rd(4'd6, v);  chk("R4", {8'd0, v}, 16'h0001);
    do_rd(4'd7, v);  chk("R4", {8'd0, v}, 16'h00C0);

    // R5: indexed wrap within the page
    do_wr(4'd6, 8'hFF);
    do_wr(4'd7, 8'h07);
    do_wr(4'd10, 8'h77);
    chk("R5", {8'd0, mem[{2'd1, 11'h001}]}, 16'h0077);
    do_rd(4'd6, v); chk("R5", {8'd0, v}, 16'h00FF);

    // R3: page follows rxq_head input when bit 15 set
    rxq_head = 2'd3;
    do_wr(4'd7, 8'h80);
    do_wr(4'd6, 8'h20);
    do_wr(4'd8, 8'h3C);
    chk("R3", {8'd0, mem[{2'd3, 11'h020}]}, 16'h003C);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule